// File: doc/BRIEF.md
# D-Channel Pair Collector

The block sits in the 2-bit D channel that passes, once per frame, between a serial-bus side and a line side. While it is disabled it only forwards: every frame the pair arriving from one side is sent out on the other. While it is enabled, the processor takes over the channel. The incoming pairs from each side are shifted into a per-side collector. After four frames each collector holds a full byte, and both bytes move at the same moment into two processor read registers. An interrupt then goes high.

In the other direction, two processor write registers hold one byte per side. These bytes are sent out two bits per frame, with the most significant pair first. The outgoing pairs follow the same four-frame slot counter that the collectors use. The interrupt stays high until the processor has read both read registers. Clearing the enable returns the slot counter and the collectors to their empty state and restores forwarding.

The interface is a small register port with a 2-bit address and single-cycle read and write strobes, plus one interrupt output. A single-cycle frame strobe marks each frame.

Top module: `dch_accum`

## Requirements
- R1: After reset, all four registers read 0, irq is 0, and both transmit outputs are 0.
- R2: While en is 0, each frame strobe loads line_tx with the bus_rx value of that cycle and bus_tx with the line_rx value of that cycle. The slot counter does not advance.
- R3: While en is 1, four frame strobes collect one byte per side. The pair from the first strobe lands in bits [7:6] and the pair from the fourth strobe lands in bits [1:0]. Both read registers take their new bytes on the clock edge of the fourth strobe. The read register for the line side is at address 1 and the one for the bus side is at address 3.
- R4: irq goes high on the clock edge of the fourth strobe of a collection, and at no other time.
- R5: irq returns to 0 only once both address 1 and address 3 have been read since the last capture, in either order. Reading one of them alone, or reading address 0 or 2, leaves irq high.
- R6: While en is 1, strobe k of a collection (k = 0 to 3) sends bits [7-2k:6-2k] of each write register. The write register at address 0 goes out on line_tx and the one at address 2 goes out on bus_tx.
- R7: A write to address 0 or 2 stores reg_wdata, and reading that address returns the stored byte.
- R8: A cycle with en at 0 discards any partly collected pairs. The next four strobes with en at 1 form a complete new byte.
- R9: The read registers keep their value on every cycle except the edge of a fourth strobe. This includes strobes 1 to 3 and cycles with no strobe.
- R10: A new capture while irq is still pending clears any earlier reads. Both read registers must then be read again before irq falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| en | input | 1 | Processor access to the D channel |
| frame_tick | input | 1 | Single-cycle frame strobe |
| line_rx | input | 2 | D pair arriving from the line side |
| bus_rx | input | 2 | D pair arriving from the serial bus |
| line_tx | output | 2 | D pair sent toward the line side |
| bus_tx | output | 2 | D pair sent toward the serial bus |
| reg_addr | input | 2 | Register select: 0 write-line, 1 read-line, 2 write-bus, 3 read-bus |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Collection-complete interrupt |

## Verification
The assertions assume that reset is held low through the first clock edges. They also assume that frame_tick is a pulse one cycle wide and that a register access carries only one of reg_wr and reg_rd in a given cycle. The stimulus keeps to these rules. Every strobe and every register access is a task that raises its strobe for exactly one cycle and drives it on the falling edge. Random pairs and random write bytes are drawn only inside these tasks. The en input is changed only on cycles with no strobe.

// File: rtl/dch_accum_pkg.sv
package dch_accum_pkg;
    typedef enum logic [1:0] {
        SEL_WR_LINE = 2'd0,
        SEL_RD_LINE = 2'd1,
        SEL_WR_BUS  = 2'd2,
        SEL_RD_BUS  = 2'd3
    } reg_sel_e;

    localparam int SIDE_LINE = 0;
    localparam int SIDE_BUS  = 1;
    localparam int N_SIDES   = 2;
endpackage

// File: rtl/dch_slot_seq.sv
module dch_slot_seq #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot,
    output logic              last_tick
);
    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == SLOT_W'(SLOTS - 1)) st_d.cnt = '0;
            else                                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot      = st_q.cnt;
    assign last_tick = en && tick && (st_q.cnt == SLOT_W'(SLOTS - 1));

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> slot == '0);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(slot));
endmodule

// File: rtl/dch_lane.sv
module dch_lane #(
    parameter int PAIR_W = 2,
    parameter int SLOTS  = 4,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int BYTE_W = PAIR_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              last_tick,
    input  logic [PAIR_W-1:0] rx_pair,
    input  logic [PAIR_W-1:0] pass_pair,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] wr_byte,
    output logic [PAIR_W-1:0] tx_pair
);
    localparam int COL_W = BYTE_W - PAIR_W;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [BYTE_W-1:0] rd;
        logic [BYTE_W-1:0] wr;
        logic [PAIR_W-1:0] tx;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) st_d.wr = wdata;
        if (!en) st_d.col = '0;
        if (tick) begin
            if (en) begin
                st_d.tx = PAIR_W'(st_q.wr >> (PAIR_W * (SLOTS - 1 - int'(slot))));
                if (last_tick) begin
                    st_d.rd  = {st_q.col, rx_pair};
                    st_d.col = '0;
                end else begin
                    st_d.col = COL_W'({st_q.col, rx_pair});
                end
            end else begin
                st_d.tx = pass_pair;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_byte = st_q.rd;
    assign wr_byte = st_q.wr;
    assign tx_pair = st_q.tx;

    // R2
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !en) |=> tx_pair == $past(pass_pair));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_tick |=> $stable(rd_byte));
    // R3
    rd_low_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_tick |=> rd_byte[PAIR_W-1:0] == $past(rx_pair));
endmodule

// File: rtl/dch_irq_ctl.sv
module dch_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic rd_a_hit,
    input  logic rd_b_hit,
    output logic irq
);
    typedef struct packed {
        logic irq;
        logic seen_a;
        logic seen_b;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.irq    = 1'b1;
            st_d.seen_a = 1'b0;
            st_d.seen_b = 1'b0;
        end else begin
            if (rd_a_hit) st_d.seen_a = 1'b1;
            if (rd_b_hit) st_d.seen_b = 1'b1;
            if (st_d.seen_a && st_d.seen_b) begin
                st_d.irq    = 1'b0;
                st_d.seen_a = 1'b0;
                st_d.seen_b = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cap));
    // R4
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> irq);
    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_a_hit || rd_b_hit));
endmodule

// File: rtl/dch_accum.sv
module dch_accum
    import dch_accum_pkg::*;
#(
    parameter int PAIR_W = 2,
    parameter int SLOTS  = 4,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int BYTE_W = PAIR_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              frame_tick,
    input  logic [PAIR_W-1:0] line_rx,
    input  logic [PAIR_W-1:0] bus_rx,
    output logic [PAIR_W-1:0] line_tx,
    output logic [PAIR_W-1:0] bus_tx,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq
);
    logic [SLOT_W-1:0] slot;
    logic              last_tick;
    logic [PAIR_W-1:0] rx_arr   [N_SIDES];
    logic [PAIR_W-1:0] tx_arr   [N_SIDES];
    logic [BYTE_W-1:0] rd_arr   [N_SIDES];
    logic [BYTE_W-1:0] wr_arr   [N_SIDES];
    logic              wstb_arr [N_SIDES];
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_addr);

    assign rx_arr[SIDE_LINE]   = line_rx;
    assign rx_arr[SIDE_BUS]    = bus_rx;
    assign wstb_arr[SIDE_LINE] = reg_wr && (sel == SEL_WR_LINE);
    assign wstb_arr[SIDE_BUS]  = reg_wr && (sel == SEL_WR_BUS);

    dch_slot_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (frame_tick),
        .slot      (slot),
        .last_tick (last_tick)
    );

    for (genvar s = 0; s < N_SIDES; s++) begin : g_lane
        dch_lane #(
            .PAIR_W (PAIR_W),
            .SLOTS  (SLOTS),
            .SLOT_W (SLOT_W),
            .BYTE_W (BYTE_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en),
            .tick      (frame_tick),
            .slot      (slot),
            .last_tick (last_tick),
            .rx_pair   (rx_arr[s]),
            .pass_pair (rx_arr[N_SIDES-1-s]),
            .wr_stb    (wstb_arr[s]),
            .wdata     (reg_wdata),
            .rd_byte   (rd_arr[s]),
            .wr_byte   (wr_arr[s]),
            .tx_pair   (tx_arr[s])
        );
    end

    assign line_tx = tx_arr[SIDE_LINE];
    assign bus_tx  = tx_arr[SIDE_BUS];

    always_comb begin
        unique case (sel)
            SEL_WR_LINE: reg_rdata = wr_arr[SIDE_LINE];
            SEL_RD_LINE: reg_rdata = rd_arr[SIDE_LINE];
            SEL_WR_BUS:  reg_rdata = wr_arr[SIDE_BUS];
            default:     reg_rdata = rd_arr[SIDE_BUS];
        endcase
    end

    dch_irq_ctl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (last_tick),
        .rd_a_hit (reg_rd && (sel == SEL_RD_LINE)),
        .rd_b_hit (reg_rd && (sel == SEL_RD_BUS)),
        .irq      (irq)
    );
endmodule

// File: tb/tb_dch_accum.sv
module tb_dch_accum;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       frame_tick = 1'b0;
    logic [1:0] line_rx = '0, bus_rx = '0;
    logic [1:0] line_tx, bus_tx;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    int total = 0;
    int bad = 0;
    logic [31:0] seed_dummy;

    always #5 clk = ~clk;

    dch_accum dut (.*);

    function automatic logic [7:0] pack4(input logic [1:0] p0, p1, p2, p3);
        return {p0, p1, p2, p3};
    endfunction

    function automatic logic [1:0] pair_of(input logic [7:0] b, input int k);
        return b[7-2*k -: 2];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [1:0] lr, input logic [1:0] br);
        line_rx = lr; bus_rx = br; frame_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [1:0] lp [4];
        logic [1:0] bp [4];
        logic [7:0] wl, wb, old_l, old_b;
        seed_dummy = $urandom(32'h5eed_0d1c);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 tx", {line_tx, bus_tx}, 0);

        // R7 write/readback
        wr(2'd0, 8'hA5); wr(2'd2, 8'h3C);
        peek(2'd0, v); chk("R7 wr line", v, 8'hA5);
        peek(2'd2, v); chk("R7 wr bus", v, 8'h3C);

        // R2 pass-through while disabled
        tick(2'b01, 2'b10);
        chk("R2 line_tx", line_tx, 2'b10);
        chk("R2 bus_tx", bus_tx, 2'b01);
        tick(2'b11, 2'b00);
        chk("R2 line_tx b", line_tx, 2'b00);
        chk("R2 bus_tx b", bus_tx, 2'b11);
        chk("R2 no irq", irq, 0);

        // R3 R4 R6 R9 random collections
        en = 1'b1;
        @(negedge clk);
        old_l = 8'h00; old_b = 8'h00;
        for (int it = 0; it < 40; it++) begin
            wl = 8'($urandom); wb = 8'($urandom);
            wr(2'd0, wl); wr(2'd2, wb);
            for (int k = 0; k < 4; k++) begin
                lp[k] = 2'($urandom); bp[k] = 2'($urandom);
                if (($urandom % 3) == 0) @(negedge clk);
                tick(lp[k], bp[k]);
                chk("R6 line_tx", line_tx, pair_of(wl, k));
                chk("R6 bus_tx", bus_tx, pair_of(wb, k));
                if (k < 3) begin
                    peek(2'd1, v); chk("R9 rd line", v, old_l);
                    peek(2'd3, v); chk("R9 rd bus", v, old_b);
                    chk("R4 irq low", irq, 0);
                end
            end
            chk("R4 irq high", irq, 1);
            old_l = pack4(lp[0], lp[1], lp[2], lp[3]);
            old_b = pack4(bp[0], bp[1], bp[2], bp[3]);
            if (it[0]) begin
                rd(2'd3, v); chk("R3 rd bus", v, old_b);
                chk("R5 one read", irq, 1);
                rd(2'd1, v); chk("R3 rd line", v, old_l);
            end else begin
                rd(2'd1, v); chk("R3 rd line", v, old_l);
                chk("R5 one read", irq, 1);
                rd(2'd3, v); chk("R3 rd bus", v, old_b);
            end
            chk("R5 cleared", irq, 0);
        end

        // R5 write addresses do not clear irq
        for (int k = 0; k < 4; k++) tick(2'b00, 2'b11);
        chk("R5 set", irq, 1);
        rd(2'd0, v); rd(2'd2, v);
        chk("R5 wr reads keep", irq, 1);
        rd(2'd1, v); rd(2'd1, v);
        chk("R5 line twice keeps", irq, 1);
        rd(2'd3, v);
        chk("R5 both clear", irq, 0);

        // R10 new capture re-arms
        for (int k = 0; k < 4; k++) tick(2'b01, 2'b01);
        rd(2'd1, v);
        for (int k = 0; k < 4; k++) tick(2'b10, 2'b10);
        rd(2'd3, v);
        chk("R10 rd bus", v, 8'hAA);
        chk("R10 still pending", irq, 1);
        rd(2'd1, v);
        chk("R10 rd line", v, 8'hAA);
        chk("R10 cleared", irq, 0);

        // R8 disable discards partial collection
        tick(2'b11, 2'b11); tick(2'b11, 2'b11);
        en = 1'b0; @(negedge clk);
        tick(2'b01, 2'b10);
        chk("R8 pass after disable", {line_tx, bus_tx}, {2'b10, 2'b01});
        en = 1'b1; @(negedge clk);
        tick(2'b00, 2'b01); tick(2'b01, 2'b10);
        tick(2'b10, 2'b11);
        chk("R8 no early irq", irq, 0);
        tick(2'b11, 2'b00);
        chk("R8 irq", irq, 1);
        peek(2'd1, v); chk("R8 rd line", v, 8'h1B);
        peek(2'd3, v); chk("R8 rd bus", v, 8'h6C);

        // R9 idle cycles change nothing
        repeat (5) @(negedge clk);
        peek(2'd1, v); chk("R9 idle line", v, 8'h1B);
        peek(2'd3, v); chk("R9 idle bus", v, 8'h6C);
        chk("R9 idle irq", irq, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule